// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is a bus master for a three-wire serial audio link. It divides the system clock down to a bit clock and produces the frame clock. It then shifts parallel PCM samples out on a single data line. The receiver is expected to sample data on the rising bit-clock edge. For that reason, the frame clock and the data line both change only on a falling bit-clock edge.

A two-bit format input picks one of four framings:

- Standard I2S, where data is delayed one bit after the frame-clock edge.
- Left-justified.
- Right-justified.
- A pulse-framed multichannel mode (DSP mode A).

The sample width and the number of bit-clock cycles per channel slot are runtime inputs. The multichannel mode also takes a channel count. The format, width, slot length and channel count are sampled once per frame, at the frame-start edge.

Samples arrive one whole frame at a time through a holding register with a valid/ready handshake. When a frame starts, the held samples move to the serializer and the holding register is free again. If nothing is held at that moment, the previous frame's samples are sent again and an underrun flag pulses.

Top module: `pcm_serial_tx`

## Requirements
- R1: `bclk_o` is low in reset. After reset it toggles every `HALF_DIV` clock cycles, so one bit-clock period is `2*HALF_DIV` clock cycles with equal high and low phases.
- R2: `fclk_o` and `sdata_o` change only on the clock cycle that follows a falling edge of the internal bit clock. Each value then holds for one whole bit-clock period.
- R3: With `fmt_sel` = 0 (I2S), `fclk_o` is low during the left slot (channel 0) and high during the right slot (channel 1). The MSB of each word is sent one bit-clock cycle after the frame clock changes.
- R4: With `fmt_sel` = 1 (left-justified), `fclk_o` is high during the left slot. The MSB of each word is sent in the first bit cycle of its slot, which is the same falling edge on which the frame clock changes.
- R5: With `fmt_sel` = 2 (right-justified), `fclk_o` is high during the left slot. The LSB of each word is sent in the last bit cycle of its slot, just before the frame clock changes.
- R6: With `fmt_sel` = 3 (DSP mode A), a frame holds `chan_cnt` slots with no gap between them, and `fclk_o` is high for exactly the first bit cycle of the frame. Channel 0's MSB follows one bit cycle later, and each later word follows directly on the one before. The channel count must be between 1 and CH_MAX, and `slot_bits` must be at least 2.
- R7: Every word is sent MSB first. Slot bit cycles that carry no sample bit are driven low, and sample-container bits at or above `word_bits` are never sent. `word_bits` must lie between 1 and `slot_bits`.
- R8: `smp_ready` is high when the holding register is empty. A word is accepted on a clock edge where both `smp_valid` and `smp_ready` are high. Channel c sits in `smp_data[c*SW_MAX +: SW_MAX]`, right-aligned in its low `word_bits` bits. The held frame reaches the serializer at the next frame start.
- R9: If the holding register is empty at a frame start, the previous frame's samples are sent again and `underrun_o` is high for exactly one clock cycle.
- R10: `fmt_sel`, `word_bits`, `slot_bits` and `chan_cnt` are sampled only at a frame start. A change in the middle of a frame first takes effect in the next frame.
- R11: In reset, `fclk_o`, `sdata_o` and `underrun_o` are low and `smp_ready` is high. The first frame starts on the first falling bit-clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP mode A |
| word_bits | input | $clog2(SW_MAX+1) | Sample width in bits |
| slot_bits | input | $clog2(SLOT_MAX+1) | Bit-clock cycles per channel slot |
| chan_cnt | input | $clog2(CH_MAX+1) | Channels per frame in DSP mode A |
| smp_valid | input | 1 | Frame of samples offered |
| smp_ready | output | 1 | Holding register empty |
| smp_data | input | CH_MAX*SW_MAX | Packed channel samples |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame (word-select) clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: no new samples at frame start |

## Verification
The internal falling-edge event updates `fclk_o` and `sdata_o` one clock later. The new values then hold until the next falling edge, so every bit is stable when `bclk_o` rises. The bench records `fclk_o` and `sdata_o` at each rising edge of `bclk_o`, sampled at the clock's falling edge. It compares bit n of frame f with a value computed from the slot arithmetic. The first record after reset precedes frame 0 and must hold reset values.

`underrun_o` is due on the clock after the frame-start edge, and the bench counts its pulses and their length over the capture window. Samples and settings applied during frame f are expected only from frame f+1 onward, and the expected streams are built that way.

// File: rtl/pst_pkg.sv
package pst_pkg;
    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ   = 2'd2,
        FMT_DSPA = 2'd3
    } fmt_e;
endpackage

// File: rtl/pst_bclk_gen.sv
module pst_bclk_gen #(
    parameter int HALF_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_evt
);
    localparam int CNTW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            ph;
    } gen_t;

    gen_t gen_d, gen_q;
    logic at_end;

    always_comb begin
        gen_d  = gen_q;
        at_end = (gen_q.cnt == CNTW'(HALF_DIV - 1));
        if (at_end) begin
            gen_d.cnt = '0;
            gen_d.ph  = !gen_q.ph;
        end else begin
            gen_d.cnt = gen_q.cnt + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign bclk     = gen_q.ph;
    assign fall_evt = at_end && gen_q.ph;

    // R1
    bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !bclk);
    // R1
    bclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !bclk) |=> bclk);
endmodule

// File: rtl/pst_sample_hold.sv
module pst_sample_hold #(
    parameter int CH_MAX = 4,
    parameter int SW_MAX = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CH_MAX*SW_MAX-1:0] in_data,
    input  logic                     take,
    output logic [CH_MAX*SW_MAX-1:0] frame_words,
    output logic                     starved
);
    localparam int FW = CH_MAX * SW_MAX;

    typedef struct packed {
        logic [FW-1:0] hold;
        logic [FW-1:0] frame;
        logic          full;
    } hold_t;

    hold_t hs_d, hs_q;

    always_comb begin
        hs_d    = hs_q;
        starved = take && !hs_q.full;
        if (take && hs_q.full) begin
            hs_d.frame = hs_q.hold;
            hs_d.full  = 1'b0;
        end
        if (in_valid && !hs_q.full) begin
            hs_d.hold = in_data;
            hs_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign in_ready    = !hs_q.full;
    assign frame_words = hs_d.frame;

    // R8
    accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R9
    starve_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        starved |=> $stable(hs_q.frame));
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pst_pkg::*;
#(
    parameter int SW_MAX   = 16,
    parameter int SLOT_MAX = 32,
    parameter int CH_MAX   = 4,
    parameter int HALF_DIV = 1,
    localparam int WBW = $clog2(SW_MAX + 1),
    localparam int SBW = $clog2(SLOT_MAX + 1),
    localparam int CBW = $clog2(CH_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               fmt_sel,
    input  logic [WBW-1:0]           word_bits,
    input  logic [SBW-1:0]           slot_bits,
    input  logic [CBW-1:0]           chan_cnt,
    input  logic                     smp_valid,
    output logic                     smp_ready,
    input  logic [CH_MAX*SW_MAX-1:0] smp_data,
    output logic                     bclk_o,
    output logic                     fclk_o,
    output logic                     sdata_o,
    output logic                     underrun_o
);
    localparam int SIW = (CH_MAX > 1) ? $clog2(CH_MAX) : 1;
    localparam int SWI = (SW_MAX > 1) ? $clog2(SW_MAX) : 1;

    typedef struct packed {
        fmt_e           fmt;
        logic [WBW-1:0] wb;
        logic [SBW-1:0] sb;
        logic [CBW-1:0] nc;
    } cfg_t;

    typedef struct packed {
        cfg_t           cfg;
        logic [SBW-1:0] k;
        logic [SIW-1:0] s;
        logic           started;
        logic           fclk;
        logic           sdata;
        logic           tail;
        logic           underrun;
    } ser_t;

    ser_t ser_d, ser_q;

    logic                     fall_evt;
    logic                     frame_wrap;
    logic                     starved;
    logic [CH_MAX*SW_MAX-1:0] frame_words;
    logic [CBW-1:0]           nslot_q;
    logic                     last_bit, last_slot;
    logic [SW_MAX-1:0]        cur_word;
    logic [SBW-1:0]           lj_idx, rj_idx;
    logic                     lj_bit, rj_bit;

    pst_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk_o),
        .fall_evt (fall_evt)
    );

    pst_sample_hold #(.CH_MAX(CH_MAX), .SW_MAX(SW_MAX)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (smp_valid),
        .in_ready    (smp_ready),
        .in_data     (smp_data),
        .take        (frame_wrap),
        .frame_words (frame_words),
        .starved     (starved)
    );

    // frame boundary detection from the registered position
    always_comb begin
        nslot_q    = (ser_q.cfg.fmt == FMT_DSPA) ? ser_q.cfg.nc : CBW'(2);
        last_bit   = (ser_q.k == ser_q.cfg.sb - SBW'(1));
        last_slot  = (CBW'(ser_q.s) == nslot_q - CBW'(1));
        frame_wrap = fall_evt && (!ser_q.started || (last_bit && last_slot));
    end

    always_comb begin
        ser_d          = ser_q;
        ser_d.underrun = 1'b0;
        cur_word       = '0;
        lj_idx         = '0;
        rj_idx         = '0;
        lj_bit         = 1'b0;
        rj_bit         = 1'b0;
        if (fall_evt) begin
            ser_d.started = 1'b1;
            if (frame_wrap) begin
                ser_d.cfg      = '{fmt: fmt_e'(fmt_sel), wb: word_bits,
                                   sb: slot_bits, nc: chan_cnt};
                ser_d.k        = '0;
                ser_d.s        = '0;
                ser_d.underrun = starved;
            end else if (last_bit) begin
                ser_d.k = '0;
                ser_d.s = ser_q.s + SIW'(1);
            end else begin
                ser_d.k = ser_q.k + SBW'(1);
            end
            cur_word = frame_words[ser_d.s*SW_MAX +: SW_MAX];
            lj_idx   = SBW'(ser_d.cfg.wb) - SBW'(1) - ser_d.k;
            rj_idx   = ser_d.cfg.sb - SBW'(1) - ser_d.k;
            lj_bit   = (ser_d.k < SBW'(ser_d.cfg.wb)) ? cur_word[lj_idx[SWI-1:0]] : 1'b0;
            rj_bit   = (rj_idx < SBW'(ser_d.cfg.wb)) ? cur_word[rj_idx[SWI-1:0]] : 1'b0;
            ser_d.tail = lj_bit;
            case (ser_d.cfg.fmt)
                FMT_I2S: begin
                    ser_d.fclk  = (ser_d.s == SIW'(1));
                    ser_d.sdata = ser_q.tail;
                end
                FMT_LJ: begin
                    ser_d.fclk  = (ser_d.s == '0);
                    ser_d.sdata = lj_bit;
                end
                FMT_RJ: begin
                    ser_d.fclk  = (ser_d.s == '0);
                    ser_d.sdata = rj_bit;
                end
                default: begin
                    ser_d.fclk  = (ser_d.s == '0) && (ser_d.k == '0);
                    ser_d.sdata = ser_q.tail;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign fclk_o     = ser_q.fclk;
    assign sdata_o    = ser_q.sdata;
    assign underrun_o = ser_q.underrun;

    // R2
    fclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fclk_o != $past(fclk_o)) |-> $past(fall_evt));
    // R2
    sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |-> $past(fall_evt));
    // R6
    dsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && fclk_o && ser_q.cfg.fmt == FMT_DSPA) |=> !fclk_o);
    // R9
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> !underrun_o);
    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(ser_q.cfg));
endmodule

// File: tb/pcm_serial_tx_tb_top.sv
module pcm_serial_tx_tb_top;
    localparam int SW   = 16;
    localparam int SL   = 32;
    localparam int CH   = 4;
    localparam int HALF = 2;
    localparam int NFR  = 4;
    localparam int FEED = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    fmt_sel = '0;
    logic [4:0]    word_bits = 5'd16;
    logic [5:0]    slot_bits = 6'd16;
    logic [2:0]    chan_cnt = 3'd2;
    logic          smp_valid = 1'b0;
    logic          smp_ready;
    logic [CH*SW-1:0] smp_data = '0;
    logic          bclk_o, fclk_o, sdata_o, underrun_o;

    pcm_serial_tx #(.SW_MAX(SW), .SLOT_MAX(SL), .CH_MAX(CH), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .word_bits(word_bits),
        .slot_bits(slot_bits), .chan_cnt(chan_cnt), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data), .bclk_o(bclk_o),
        .fclk_o(fclk_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
    );

    int n_vec = 0, n_bad = 0;
    bit cap_f [0:1023];
    bit cap_d [0:1023];
    int cap_n, cap_target;
    bit cap_on = 1'b0;
    int ur_pulses, ur_run, ur_maxrun;
    bit bclk_prev;
    int run_len, run_bad;
    bit run_first;
    logic [SW-1:0] dat [0:NFR-1][0:CH-1];
    int ffmt [0:NFR-1];
    int W, S, L;

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // observation of the serial link at the clock's falling edge
    always @(negedge clk) begin
        if (cap_on) begin
            if (bclk_o && !bclk_prev) begin
                cap_f[cap_n] = fclk_o;
                cap_d[cap_n] = sdata_o;
                cap_n++;
                if (cap_n == cap_target) cap_on = 1'b0;
            end
            if (underrun_o) begin
                ur_run++;
                if (ur_run == 1) ur_pulses++;
                if (ur_run > ur_maxrun) ur_maxrun = ur_run;
            end else begin
                ur_run = 0;
            end
            if (bclk_o == bclk_prev) run_len++;
            else begin
                if (!run_first && run_len != HALF) run_bad++;
                run_first = 1'b0;
                run_len   = 1;
            end
            bclk_prev = bclk_o;
        end
    end

    function automatic bit ljb(int f, int p);
        int s = p / S;
        int k = p % S;
        if (k < W) return dat[f][s][W-1-k];
        return 1'b0;
    endfunction

    function automatic bit rjb(int f, int p);
        int s = p / S;
        int r = S - 1 - (p % S);
        if (r < W) return dat[f][s][r];
        return 1'b0;
    endfunction

    function automatic bit exp_d(int f, int p);
        if (ffmt[f] == 1) return ljb(f, p);
        if (ffmt[f] == 2) return rjb(f, p);
        if (p == 0) return (f == 0) ? 1'b0 : ljb(f - 1, L - 1);
        return ljb(f, p - 1);
    endfunction

    function automatic bit exp_f(int f, int p);
        case (ffmt[f])
            0:       return (p / S) == 1;
            3:       return p == 0;
            default: return (p / S) == 0;
        endcase
    endfunction

    function automatic string tag_of(int fm);
        case (fm)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_cfg(int fm, int w, int s, int c, bit mix);
        int nsl;
        W = w; S = s;
        nsl = (fm == 3) ? c : 2;
        L = nsl * s;
        for (int f = 0; f < NFR; f++) ffmt[f] = fm;
        if (mix) begin
            ffmt[0] = 1; ffmt[1] = 0; ffmt[2] = 2; ffmt[3] = 1;
        end
        for (int f = 0; f < FEED; f++)
            for (int ch = 0; ch < CH; ch++)
                dat[f][ch] = 16'(f * 7919 + ch * 613 + w * 97 + s * 31 + fm * 5 + 'h5A3C);
        for (int ch = 0; ch < CH; ch++) dat[NFR-1][ch] = dat[FEED-1][ch];

        rst_n     = 1'b0;
        fmt_sel   = 2'(ffmt[0]);
        word_bits = 5'(w);
        slot_bits = 6'(s);
        chan_cnt  = 3'(c);
        smp_valid = 1'b0;
        cap_n = 0; cap_target = 1 + NFR * L;
        ur_pulses = 0; ur_run = 0; ur_maxrun = 0;
        run_len = 0; run_bad = 0; run_first = 1'b1; bclk_prev = 1'b0;
        cap_on = 1'b1;
        repeat (2) @(negedge clk);
        // R11 reset state
        chk("R11 bclk", int'(bclk_o), 0);
        chk("R11 fclk", int'(fclk_o), 0);
        chk("R11 sdata", int'(sdata_o), 0);
        chk("R11 underrun", int'(underrun_o), 0);
        chk("R11 ready", int'(smp_ready), 1);
        rst_n = 1'b1;
        fork
            begin
                for (int f = 0; f < FEED; f++) begin
                    for (int ch = 0; ch < CH; ch++) smp_data[ch*SW +: SW] = dat[f][ch];
                    smp_valid = 1'b1;
                    while (!smp_ready) @(negedge clk);
                    @(negedge clk);
                    smp_valid = 1'b0;
                end
            end
            begin
                if (mix) begin
                    for (int f = 0; f < NFR - 1; f++) begin
                        wait (cap_n >= 1 + f * L + L / 2);
                        @(negedge clk);
                        fmt_sel = 2'(ffmt[f+1]);
                    end
                end
            end
        join
        wait (!cap_on);
        // R11 first record precedes frame 0
        chk("R11 pre fclk", int'(cap_f[0]), 0);
        chk("R11 pre sdata", int'(cap_d[0]), 0);
        for (int f = 0; f < NFR; f++)
            for (int p = 0; p < L; p++) begin
                chk({tag_of(ffmt[f]), mix ? " R10" : "", " fclk"},
                    int'(cap_f[1 + f*L + p]), int'(exp_f(f, p)));
                chk({tag_of(ffmt[f]), " R7 R8 R9 sdata"},
                    int'(cap_d[1 + f*L + p]), int'(exp_d(f, p)));
            end
        chk("R9 underrun pulses", ur_pulses, 1);
        chk("R9 underrun length", ur_maxrun, 1);
        chk("R1 bclk half period", run_bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int pw [0:4];
        int ps [0:4];
        pw[0] = 16; ps[0] = 16;
        pw[1] = 8;  ps[1] = 16;
        pw[2] = 5;  ps[2] = 12;
        pw[3] = 16; ps[3] = 32;
        pw[4] = 1;  ps[4] = 2;
        for (int fm = 0; fm < 3; fm++)
            for (int i = 0; i < 5; i++) run_cfg(fm, pw[i], ps[i], 3, 1'b0);
        for (int c = 1; c <= CH; c++)
            for (int i = 0; i < 5; i++) run_cfg(3, pw[i], ps[i], c, 1'b0);
        run_cfg(1, 8, 16, 2, 1'b1);
        run_cfg(1, 16, 16, 2, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule